// File: doc/BRIEF.md
# Four-Tap Orthogonal Wavelet Synthesis Interpolator

This block performs one level of inverse discrete wavelet reconstruction. Each accepted input carries one approximation (low-band) coefficient and one detail (high-band) coefficient. Conceptually, each coefficient stream is up-sampled by placing a zero after every coefficient. Each up-sampled stream then passes through its own four-tap reconstruction filter, and the two filter outputs are added. The sum is the rebuilt signal at twice the coefficient rate. Adding the two branches cancels the aliasing left by the analysis split.

The hardware never multiplies by the inserted zeros. For every accepted pair it computes the two output phases at once: the even phase uses filter taps 0 and 2, and the odd phase uses taps 1 and 3. It emits the even sample on the next cycle and the odd sample on the cycle after that. The source must leave at least one idle cycle between pairs. The filter taps are quantized to Q1.8 (eight fraction bits). The sum is rounded and clipped to a signed 8-bit sample.

Top module: `dbrec_synth`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first pair has been accepted.
- R2: Filter taps in Q1.8 integers, index 0 first: low band -33, 57, 214, 124; high band 124, -214, 57, 33.
- R3: One cycle after a cycle with `in_valid` high, `out_valid` is 1 and `out_sample` carries the even phase: sat(rnd(L0*a[m] + L2*a[m-1] + H0*d[m] + H2*d[m-1])).
- R4: Two cycles after an accepted pair, `out_valid` is 1 and `out_sample` carries the odd phase: sat(rnd(L1*a[m] + L3*a[m-1] + H1*d[m] + H3*d[m-1])). The result is identical to filtering the zero-stuffed streams.
- R5: a[m-1] and d[m-1] are the coefficients of the previously accepted pair. Reset clears them to zero.
- R6: Rounding is rnd(s) = floor((s + 128) / 256), which adds one half and then shifts arithmetically.
- R7: The rounded value is clipped to the range -128..127.
- R8: When `out_valid` is low, `out_sample` keeps its previous value.
- R9: The source never asserts `in_valid` in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A coefficient pair is present |
| approx_in | input | CW | Signed low-band coefficient |
| detail_in | input | CW | Signed high-band coefficient |
| out_valid | output | 1 | `out_sample` holds a new reconstructed sample |
| out_sample | output | OW | Signed reconstructed sample |

## Verification
The bench builds the block with CW = 10 and OW = 8. Full-scale coefficients of ±511 drive the phase sums far beyond the 8-bit range, which exercises clipping at both ends. Small coefficients fall inside the rounding band, so the half-LSB bias and the floor on negative sums are both tested. The reference model filters explicitly zero-stuffed streams with the full four-tap filters. It therefore checks the polyphase shortcut against the direct form on impulses, clipping cases, a mid-run reset and random pairs with random gaps.

// File: rtl/dbrec_pkg.sv
package dbrec_pkg;
  // Tap word width and fraction bits (Q1.8)
  localparam int TAP_W = 10;
  localparam int FRAC  = 8;
  // Reconstruction filters, tap 0 first
  localparam int LO_TAP [4] = '{-33, 57, 214, 124};
  localparam int HI_TAP [4] = '{124, -214, 57, 33};
endpackage

// File: rtl/dbrec_phase_mac.sv
// One polyphase branch: two taps per band, applied to the current and previous coefficient
module dbrec_phase_mac #(
  parameter int CW     = 10,
  parameter int TW     = 10,
  parameter int SW     = 22,
  parameter int A_NOW  = 0,
  parameter int A_OLD  = 0,
  parameter int D_NOW  = 0,
  parameter int D_OLD  = 0
) (
  input  logic signed [CW-1:0] a_now,
  input  logic signed [CW-1:0] a_old,
  input  logic signed [CW-1:0] d_now,
  input  logic signed [CW-1:0] d_old,
  output logic signed [SW-1:0] acc
);
  localparam int PW = CW + TW;
  localparam logic signed [TW-1:0] KA_NOW = TW'(A_NOW);
  localparam logic signed [TW-1:0] KA_OLD = TW'(A_OLD);
  localparam logic signed [TW-1:0] KD_NOW = TW'(D_NOW);
  localparam logic signed [TW-1:0] KD_OLD = TW'(D_OLD);

  logic signed [PW-1:0] p_an, p_ao, p_dn, p_do;

  always_comb begin
    p_an = PW'(a_now) * PW'(KA_NOW);
    p_ao = PW'(a_old) * PW'(KA_OLD);
    p_dn = PW'(d_now) * PW'(KD_NOW);
    p_do = PW'(d_old) * PW'(KD_OLD);
    acc  = SW'(p_an) + SW'(p_ao) + SW'(p_dn) + SW'(p_do);
  end
endmodule

// File: rtl/dbrec_round_sat.sv
// Round half up with arithmetic shift, then clip to OW signed bits
module dbrec_round_sat #(
  parameter int SW   = 22,
  parameter int FRAC = 8,
  parameter int OW   = 8
) (
  input  logic signed [SW-1:0] sum_in,
  output logic signed [OW-1:0] res
);
  localparam logic signed [SW-1:0] HALF = SW'(1 <<< (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 <<< (OW - 1));

  logic signed [SW-1:0] biased, shifted;

  always_comb begin
    biased  = sum_in + HALF;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      res = MAXV[OW-1:0];
    else if (shifted < MINV) res = MINV[OW-1:0];
    else                     res = shifted[OW-1:0];
  end
endmodule

// File: rtl/dbrec_synth.sv
module dbrec_synth
  import dbrec_pkg::*;
#(
  parameter int CW = 10,
  parameter int OW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [CW-1:0] approx_in,
  input  logic signed [CW-1:0] detail_in,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);
  localparam int SW     = CW + TAP_W + 2;
  localparam int PHASES = 2;

  // Previous pair history
  logic signed [CW-1:0] a_old_q, a_old_d, d_old_q, d_old_d;
  // Output sequencing
  logic                 odd_pend_q, odd_pend_d;
  logic signed [OW-1:0] odd_hold_q, odd_hold_d;
  logic                 vld_d;
  logic signed [OW-1:0] smp_d;

  logic signed [SW-1:0] phase_sum [PHASES];
  logic signed [OW-1:0] phase_res [PHASES];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    dbrec_phase_mac #(
      .CW(CW), .TW(TAP_W), .SW(SW),
      .A_NOW(LO_TAP[p]), .A_OLD(LO_TAP[p+2]),
      .D_NOW(HI_TAP[p]), .D_OLD(HI_TAP[p+2])
    ) u_mac (
      .a_now(approx_in), .a_old(a_old_q),
      .d_now(detail_in), .d_old(d_old_q),
      .acc(phase_sum[p])
    );
    dbrec_round_sat #(.SW(SW), .FRAC(FRAC), .OW(OW)) u_rs (
      .sum_in(phase_sum[p]),
      .res(phase_res[p])
    );
  end

  // Next-state logic
  always_comb begin
    a_old_d    = a_old_q;
    d_old_d    = d_old_q;
    odd_pend_d = odd_pend_q;
    odd_hold_d = odd_hold_q;
    vld_d      = 1'b0;
    smp_d      = out_sample;
    if (in_valid) begin
      a_old_d    = approx_in;
      d_old_d    = detail_in;
      odd_hold_d = phase_res[1];
      odd_pend_d = 1'b1;
      vld_d      = 1'b1;
      smp_d      = phase_res[0];
    end else if (odd_pend_q) begin
      odd_pend_d = 1'b0;
      vld_d      = 1'b1;
      smp_d      = odd_hold_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_old_q    <= '0;
      d_old_q    <= '0;
      odd_pend_q <= 1'b0;
      odd_hold_q <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      a_old_q    <= a_old_d;
      d_old_q    <= d_old_d;
      odd_pend_q <= odd_pend_d;
      odd_hold_q <= odd_hold_d;
      out_valid  <= vld_d;
      out_sample <= smp_d;
    end
  end

  // R3
  even_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R4
  odd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));
  // R9
  in_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid);
  // R3
  no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) || $past(in_valid, 2)));
endmodule

// File: tb/dbrec_synth_test.sv
module dbrec_synth_test;
  localparam int CW = 10;
  localparam int OW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [CW-1:0] approx_in = '0;
  logic signed [CW-1:0] detail_in = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_sample;

  always #2 clk = ~clk;

  dbrec_synth #(.CW(CW), .OW(OW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .approx_in(approx_in), .detail_in(detail_in),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  int n_chk = 0;
  int n_bad = 0;
  string phase_tag = "R1";

  // Reference: explicit zero-stuffed streams through full four-tap filters (R2)
  int lo_t [4] = '{-33, 57, 214, 124};
  int hi_t [4] = '{124, -214, 57, 33};
  int up_a [$];
  int up_d [$];
  bit exp_vld = 0;
  int exp_val = 0;
  bit pend = 0;
  int odd_val = 0;
  bit exp_odd = 0;

  function automatic int rnd_sat(int s);
    int r;
    r = (s + 128) >>> 8;           // R6
    if (r > 127) r = 127;          // R7
    if (r < -128) r = -128;
    return r;
  endfunction

  function automatic int filt();
    int s = 0;
    for (int k = 0; k < 4; k++) s += lo_t[k] * up_a[k] + hi_t[k] * up_d[k];
    return s;
  endfunction

  task automatic clear_model();
    up_a = '{0, 0, 0, 0};
    up_d = '{0, 0, 0, 0};
    exp_vld = 0; exp_val = 0; pend = 0; odd_val = 0; exp_odd = 0;
  endtask

  initial clear_model();

  always @(posedge clk) begin
    if (!rst_n) clear_model();
    else if (in_valid) begin
      up_a.push_front(int'(approx_in)); void'(up_a.pop_back());
      up_d.push_front(int'(detail_in)); void'(up_d.pop_back());
      exp_val = rnd_sat(filt());
      up_a.push_front(0); void'(up_a.pop_back());
      up_d.push_front(0); void'(up_d.pop_back());
      odd_val = rnd_sat(filt());
      exp_vld = 1; pend = 1; exp_odd = 0;
    end else if (pend) begin
      exp_val = odd_val; exp_vld = 1; pend = 0; exp_odd = 1;
    end else exp_vld = 0;
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string req;
      req = !exp_vld ? "R8" : (exp_odd ? "R4" : "R3");
      n_chk++;
      if (out_valid !== exp_vld || int'(out_sample) != exp_val) begin
        n_bad++;
        $display("FAIL %s/%s: valid=%0b sample=%0d expected valid=%0b sample=%0d",
                 req, phase_tag, out_valid, out_sample, exp_vld, exp_val);
      end
    end
  end

  task automatic send(int a, int d, int gap);
    @(negedge clk);
    in_valid = 1'b1; approx_in = CW'(a); detail_in = CW'(d);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_reset_state();
    n_chk++;
    if (out_valid !== 1'b0 || out_sample !== '0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b sample=%0d expected valid=0 sample=0", out_valid, out_sample);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();

    phase_tag = "R2 low impulse";
    send(256, 0, 1); repeat (3) send(0, 0, 1);
    phase_tag = "R2 high impulse";
    send(0, 256, 0); repeat (3) send(0, 0, 2);

    phase_tag = "R5 history";
    send(100, -50, 0); send(-200, 30, 1); send(7, 7, 0);

    phase_tag = "R6 rounding";
    send(1, 0, 1); send(3, 0, 1); send(-4, 0, 1); send(0, -1, 1); send(2, 2, 1);

    phase_tag = "R7 saturation";
    send(511, 511, 1); send(511, 511, 1); send(-512, -512, 1); send(-512, -512, 1);
    send(511, -512, 1); send(-512, 511, 1);

    phase_tag = "R1 mid-run reset";
    send(300, -300, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check_reset_state();
    rst_n = 1'b1;
    @(negedge clk); check_reset_state();
    phase_tag = "R5 cleared history";
    send(40, 90, 2);

    phase_tag = "R3/R4 random";
    for (int i = 0; i < 400; i++) begin
      int a, d;
      a = int'($urandom_range(1023)) - 512;
      d = int'($urandom_range(1023)) - 512;
      send(a, d, int'($urandom_range(3)));
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule